// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a set of sources (twenty by default) and presents one interrupt line to a single processor. Each source has its own configuration register. The register sets how the input is interpreted: active high or active low, edge or level. It also holds a 4-bit priority, an 8-bit vector and an enable mask. A read-only activity flag in the same register shows whether the source is requesting or being serviced. The processor raises a current-task priority threshold to hold off interrupts and lowers it to let them through.

The processor talks to the block over a simple word-addressed register bus. Reading the acknowledge location returns the vector of the winning source and marks that source as in service. Writing any value to the end-of-interrupt location retires the highest-priority source that is in service. In-service tracking allows nesting: a new request interrupts only if it outranks everything already being serviced. Setting the top bit of the global control word returns every register to its default.

Top module: `vpic_top`

## Requirements
- R1: After reset every source register reads 0x80800000 (mask bit 31 set, activity bit 30 clear, polarity bit 23 set, sense bit 22 clear, priority bits 19:16 zero, vector bits 7:0 zero). The threshold register (word address 1) reads 15, `irq_out` is low, and an acknowledge read returns 0xFF.
- R2: A source register sits at word address 32+i. It reads back the mask, polarity, sense, priority and vector fields at the bit positions given in R1. All other bits read zero.
- R3: The activity bit is 1 whenever the source is requesting or in service, even if it is masked. Writes to the activity bit have no effect.
- R4: While the activity bit is 1, a write to the source register leaves polarity, sense, priority and vector unchanged. The mask bit is still updated.
- R5: The threshold register (word address 1, bits 3:0) gates interrupts. A source interrupts only if its priority is strictly greater than the threshold. A threshold of 15 blocks everything.
- R6: Sense 0 selects edge mode: a change to the active level latches a request, which stays until it is acknowledged. Sense 1 selects level mode: the source requests only while its input is at the active level.
- R7: An acknowledge read (word address 2) returns the vector of the winning source. The winner is the highest-priority source that is requesting, unmasked and not in service, with the lower index winning ties. If that source does not qualify, the read returns 0xFF and changes nothing.
- R8: A qualifying acknowledge clears that source's edge latch and sets its in-service state. `irq_out` is low in the cycle after the acknowledge read and is re-evaluated one cycle later.
- R9: A candidate must also outrank the highest priority already in service. A write to the end-of-interrupt location (word address 3) retires the highest-priority in-service source.
- R10: A source with priority 0 never interrupts, and a masked source never interrupts.
- R11: Writing bit 31 of the global control word (word address 0) sets that bit. On the next cycle every register returns to its default and the bit reads 0 again.
- R12: Polarity 1 treats a high input as active; polarity 0 treats a low input as active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | N_SRC | Raw source request inputs |
| bus_addr | input | ADDR_W | Word address of register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for acknowledge side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_out | output | 1 | Registered interrupt request to processor |

## Verification
Some properties are checked on every cycle:
- the interrupt line drops right after any acknowledge read;
- the reset bit clears itself after one cycle;
- a full threshold keeps the line low;
- each qualifying acknowledge adds exactly one in-service source, and each end-of-interrupt removes exactly one.

Other behaviours show up only in bench scenarios, which compare the design against a reference model:
- vector selection under ties and nesting;
- edge latching versus level following, under both polarities;
- writes dropped while the activity bit is set;
- the full default state after a soft reset.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned PRIO_W    = 4;
    localparam int unsigned VEC_W     = 8;
    localparam int unsigned BIT_MASK  = 31;
    localparam int unsigned BIT_ACT   = 30;
    localparam int unsigned BIT_POL   = 23;
    localparam int unsigned BIT_SENSE = 22;
    localparam int unsigned PRIO_LSB  = 16;
    localparam int unsigned VEC_LSB   = 0;
    localparam int unsigned BIT_RST   = 31;
    localparam int unsigned OFS_GCR   = 0;
    localparam int unsigned OFS_CTP   = 1;
    localparam int unsigned OFS_ACK   = 2;
    localparam int unsigned OFS_EOI   = 3;

    function automatic logic [DATA_W-1:0] pack_src(
        input logic              mask,
        input logic              act,
        input logic              pol,
        input logic              sense,
        input logic [PRIO_W-1:0] prio,
        input logic [VEC_W-1:0]  vec
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_MASK]              = mask;
        w[BIT_ACT]               = act;
        w[BIT_POL]               = pol;
        w[BIT_SENSE]             = sense;
        w[PRIO_LSB +: PRIO_W]    = prio;
        w[VEC_LSB +: VEC_W]      = vec;
        return w;
    endfunction
endpackage

// File: rtl/vpic_prio_pick.sv
module vpic_prio_pick #(
    parameter int unsigned N  = 20,
    parameter int unsigned PW = 4,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         req_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic                 any_o,
    output logic [IW-1:0]        idx_o,
    output logic [PW-1:0]        prio_o
);
    // Strict comparison keeps the lowest index among equal priorities.
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (req_i[i] && (!any_o || (prio_i[i] > prio_o))) begin
                any_o  = 1'b1;
                idx_o  = IW'(i);
                prio_o = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/vpic_src_cond.sv
module vpic_src_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic raw_i,
    input  logic pol_i,
    output logic act_o,
    output logic rise_o
);
    typedef struct packed {
        logic smp;
        logic prev;
    } cond_t;

    cond_t c_d, c_q;

    always_comb begin
        act_o  = pol_i ? c_q.smp : ~c_q.smp;
        rise_o = act_o & ~c_q.prev;
        c_d.smp  = raw_i;
        c_d.prev = act_o;
        if (clr_i) c_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int unsigned N_SRC  = 20,
    parameter int unsigned ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   irq_src,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);
    localparam int unsigned IW       = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int unsigned SRC_BASE = 1 << (ADDR_W - 1);

    typedef struct packed {
        logic [N_SRC-1:0]             mask;
        logic [N_SRC-1:0]             pol;
        logic [N_SRC-1:0]             sense;
        logic [N_SRC-1:0]             pend;
        logic [N_SRC-1:0]             insvc;
        logic [N_SRC-1:0][PRIO_W-1:0] prio;
        logic [N_SRC-1:0][VEC_W-1:0]  vec;
        logic [PRIO_W-1:0]            ctp;
        logic                         rst_pend;
        logic                         irq;
    } st_t;

    st_t s_d, s_q, s_rst;

    logic [N_SRC-1:0]  act, rise, pend_eff, activity, req;
    logic              win_any, isv_any, qualify;
    logic [IW-1:0]     win_idx, isv_idx, src_sel;
    logic [PRIO_W-1:0] win_prio, isv_prio;
    logic [VEC_W-1:0]  win_vec;
    logic [ADDR_W-1:0] src_off;
    logic              gcr_hit, ctp_hit, ack_hit, eoi_hit, src_hit;
    logic              ack_take, eoi_take;

    // Per-source input conditioning
    for (genvar g = 0; g < int'(N_SRC); g++) begin : g_src
        vpic_src_cond u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (s_q.rst_pend),
            .raw_i  (irq_src[g]),
            .pol_i  (s_q.pol[g]),
            .act_o  (act[g]),
            .rise_o (rise[g])
        );
    end

    always_comb begin
        pend_eff = (s_q.sense & act) | (~s_q.sense & s_q.pend);
        activity = pend_eff | s_q.insvc;
        req      = pend_eff & ~s_q.mask & ~s_q.insvc;
    end

    vpic_prio_pick #(.N(N_SRC), .PW(PRIO_W), .IW(IW)) u_win (
        .req_i (req),
        .prio_i(s_q.prio),
        .any_o (win_any),
        .idx_o (win_idx),
        .prio_o(win_prio)
    );

    vpic_prio_pick #(.N(N_SRC), .PW(PRIO_W), .IW(IW)) u_isv (
        .req_i (s_q.insvc),
        .prio_i(s_q.prio),
        .any_o (isv_any),
        .idx_o (isv_idx),
        .prio_o(isv_prio)
    );

    // Address decode
    always_comb begin
        gcr_hit = (bus_addr == ADDR_W'(OFS_GCR));
        ctp_hit = (bus_addr == ADDR_W'(OFS_CTP));
        ack_hit = (bus_addr == ADDR_W'(OFS_ACK));
        eoi_hit = (bus_addr == ADDR_W'(OFS_EOI));
        src_off = bus_addr - ADDR_W'(SRC_BASE);
        src_hit = bus_addr[ADDR_W-1] && (src_off < ADDR_W'(N_SRC));
        src_sel = src_off[IW-1:0];
    end

    always_comb begin
        qualify  = win_any && (win_prio > s_q.ctp) && (win_prio > isv_prio);
        ack_take = bus_rd && ack_hit && qualify;
        eoi_take = bus_wr && eoi_hit && isv_any;
        win_vec  = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (win_idx == IW'(i)) win_vec = s_q.vec[i];
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (gcr_hit) begin
            bus_rdata[BIT_RST] = s_q.rst_pend;
        end else if (ctp_hit) begin
            bus_rdata[PRIO_W-1:0] = s_q.ctp;
        end else if (ack_hit) begin
            bus_rdata[VEC_W-1:0] = qualify ? win_vec : '1;
        end else if (src_hit) begin
            for (int i = 0; i < int'(N_SRC); i++) begin
                if (src_sel == IW'(i)) begin
                    bus_rdata = pack_src(s_q.mask[i], activity[i], s_q.pol[i],
                                         s_q.sense[i], s_q.prio[i], s_q.vec[i]);
                end
            end
        end
    end

    always_comb begin
        s_rst      = '0;
        s_rst.mask = '1;
        s_rst.pol  = '1;
        s_rst.ctp  = '1;
    end

    // Next-state
    always_comb begin
        s_d     = s_q;
        s_d.irq = qualify && !(bus_rd && ack_hit);
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (bus_wr && src_hit && (src_sel == IW'(i))) begin
                s_d.mask[i] = bus_wdata[BIT_MASK];
                if (!activity[i]) begin
                    s_d.pol[i]   = bus_wdata[BIT_POL];
                    s_d.sense[i] = bus_wdata[BIT_SENSE];
                    s_d.prio[i]  = bus_wdata[PRIO_LSB +: PRIO_W];
                    s_d.vec[i]   = bus_wdata[VEC_LSB +: VEC_W];
                end
            end
            if (s_q.sense[i]) begin
                s_d.pend[i] = 1'b0;
            end else begin
                if (ack_take && (win_idx == IW'(i))) s_d.pend[i] = 1'b0;
                if (rise[i])                         s_d.pend[i] = 1'b1;
            end
            if (ack_take && (win_idx == IW'(i))) s_d.insvc[i] = 1'b1;
            if (eoi_take && (isv_idx == IW'(i))) s_d.insvc[i] = 1'b0;
        end
        if (bus_wr && ctp_hit) s_d.ctp = bus_wdata[PRIO_W-1:0];
        if (bus_wr && gcr_hit && bus_wdata[BIT_RST]) s_d.rst_pend = 1'b1;
        if (s_q.rst_pend) s_d = s_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= s_rst;
        else        s_q <= s_d;
    end

    assign irq_out = s_q.irq;

    // R8: line is low right after any acknowledge read
    p_irq_drop_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ack_hit) |=> !irq_out)
        else $error("p_irq_drop_after_ack_r8");

    // R8: a qualifying acknowledge adds exactly one in-service source
    p_ack_adds_insvc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !s_q.rst_pend) |=>
            ($countones(s_q.insvc) == $countones($past(s_q.insvc)) + 1))
        else $error("p_ack_adds_insvc_r8");

    // R9: end-of-interrupt retires exactly one in-service source
    p_eoi_drops_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_take && !s_q.rst_pend) |=>
            ($countones(s_q.insvc) + 1 == $countones($past(s_q.insvc))))
        else $error("p_eoi_drops_one_r9");

    // R5: a full threshold keeps the line low
    p_full_ctp_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctp == '1) |=> !irq_out)
        else $error("p_full_ctp_blocks_r5");

    // R11: soft reset bit clears itself after one cycle
    p_rst_selfclear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rst_pend |=> !s_q.rst_pend)
        else $error("p_rst_selfclear_r11");
endmodule

// File: tb/vpic_top_tb_top.sv
`timescale 1ns/1ps
module vpic_top_tb_top;
    import vpic_pkg::*;
    localparam int N = 20;
    localparam int AW = 6;
    localparam int SB = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_src = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit m_mask[N], m_pol[N], m_sense[N], m_pend[N], m_insvc[N], m_prev[N], m_in[N];
    int m_prio[N], m_vec[N];
    int m_ctp;

    always #10 clk = ~clk;

    vpic_top #(.N_SRC(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_act(int i);
        return m_pol[i] ? m_in[i] : !m_in[i];
    endfunction

    function automatic bit m_activity(int i);
        return (m_sense[i] ? m_act(i) : m_pend[i]) | m_insvc[i];
    endfunction

    function automatic int m_isv_prio();
        int mx = 0;
        for (int i = 0; i < N; i++) if (m_insvc[i] && m_prio[i] > mx) mx = m_prio[i];
        return mx;
    endfunction

    // index of qualifying winner, -1 if none
    function automatic int m_winner();
        int best = -1;
        for (int i = 0; i < N; i++) begin
            bit r = (m_sense[i] ? m_act(i) : m_pend[i]) && !m_mask[i] && !m_insvc[i];
            if (r && (best < 0 || m_prio[i] > m_prio[best])) best = i;
        end
        if (best >= 0 && (m_prio[best] <= m_ctp || m_prio[best] <= m_isv_prio())) best = -1;
        return best;
    endfunction

    function automatic int m_eoi_idx();
        int best = -1;
        for (int i = 0; i < N; i++)
            if (m_insvc[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
        return best;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < N; i++) begin
            m_mask[i] = 1; m_pol[i] = 1; m_sense[i] = 0; m_pend[i] = 0;
            m_insvc[i] = 0; m_prev[i] = 0; m_prio[i] = 0; m_vec[i] = 0;
        end
        m_ctp = 15;
    endfunction

    function automatic void m_eval();
        for (int i = 0; i < N; i++) begin
            bit a = m_act(i);
            if (!m_sense[i]) begin
                if (a && !m_prev[i]) m_pend[i] = 1;
            end else m_pend[i] = 0;
            m_prev[i] = a;
        end
    endfunction

    task automatic bus_write(input int a, input logic [31:0] d);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        bus_addr = AW'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle(input string tag);
        repeat (4) @(negedge clk);
        m_eval();
        check(irq_out == (m_winner() >= 0), {tag, " irq"}, irq_out, m_winner() >= 0);
    endtask

    task automatic chk_src(input int i, input string tag);
        logic [31:0] d, e;
        bus_read(SB + i, d);
        e = pack_src(m_mask[i], m_activity(i), m_pol[i], m_sense[i], 4'(m_prio[i]), 8'(m_vec[i]));
        check(d == e, tag, d, e);
    endtask

    task automatic cfg(input int i, input bit mk, input bit pl, input bit sn,
                       input int pr, input int vc, input string tag);
        bit busy = m_activity(i);
        bus_write(SB + i, pack_src(mk, 1'b0, pl, sn, 4'(pr), 8'(vc)));
        m_mask[i] = mk;
        if (!busy) begin
            m_pol[i] = pl; m_sense[i] = sn; m_prio[i] = pr; m_vec[i] = vc;
        end
        settle(tag);
    endtask

    task automatic set_in(input int i, input bit v, input string tag);
        m_in[i] = v;
        irq_src[i] = v;
        settle(tag);
    endtask

    task automatic set_ctp(input int v, input string tag);
        bus_write(OFS_CTP, 32'(v));
        m_ctp = v;
        settle(tag);
    endtask

    task automatic do_ack(input string tag);
        logic [31:0] d;
        int w = m_winner();
        int e = (w < 0) ? 255 : m_vec[w];
        bus_read(OFS_ACK, d);
        check(d == 32'(e), {tag, " vector"}, d, e);
        check(irq_out == 1'b0, "R8 drop after ack", irq_out, 0);
        if (w >= 0) begin
            m_pend[w] = 0;
            m_insvc[w] = 1;
        end
        settle(tag);
    endtask

    task automatic do_eoi(input string tag);
        int k = m_eoi_idx();
        bus_write(OFS_EOI, 32'h0);
        if (k >= 0) m_insvc[k] = 0;
        settle(tag);
    endtask

    task automatic soft_reset();
        logic [31:0] d;
        bus_write(OFS_GCR, 32'h8000_0000);
        bus_read(OFS_GCR, d);
        check(d[31] == 1'b1, "R11 bit set", d, 32'h8000_0000);
        bus_read(OFS_GCR, d);
        check(d == 32'h0, "R11 bit cleared", d, 0);
        m_reset();
        settle("R11");
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd7011));
        m_reset();
        for (int i = 0; i < N; i++) m_in[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq_out == 1'b0, "R1 irq", irq_out, 0);
        for (int i = 0; i < N; i++) chk_src(i, "R1 src reset");
        bus_read(OFS_CTP, d);
        check(d == 32'd15, "R1 ctp", d, 15);
        bus_read(OFS_ACK, d);
        check(d == 32'hFF, "R1 ack spurious", d, 255);

        // R2 field layout
        cfg(3, 1, 1, 0, 9, 8'h5A, "R2");
        chk_src(3, "R2 readback");

        // R5 threshold, R6 edge latch
        cfg(3, 0, 1, 0, 9, 8'h5A, "R5");
        set_in(3, 1, "R5 full threshold");
        do_ack("R7 spurious under threshold");
        set_ctp(9, "R5 equal threshold");
        set_ctp(8, "R5 below threshold");
        chk_src(3, "R3 activity");
        cfg(3, 1, 1, 0, 9, 8'h5A, "R10 masked");
        chk_src(3, "R3 activity while masked");
        cfg(3, 0, 0, 1, 2, 8'h11, "R4 write while active");
        chk_src(3, "R4 fields kept");
        set_in(3, 0, "R6 edge latch holds");
        do_ack("R7 edge winner");
        do_eoi("R9 retire");
        chk_src(3, "R3 idle");

        // R12 active low level
        cfg(5, 0, 0, 1, 7, 8'h22, "R12 active low");
        set_in(5, 1, "R12 inactive high");

        // R7 tie and R9 nesting
        set_ctp(0, "R5");
        cfg(6, 0, 1, 1, 10, 8'h66, "R7");
        cfg(7, 0, 1, 1, 10, 8'h77, "R7");
        set_in(7, 1, "R6 level");
        set_in(6, 1, "R6 level");
        do_ack("R7 tie lower index");
        cfg(8, 0, 1, 1, 12, 8'h88, "R9");
        set_in(8, 1, "R9 higher nests");
        do_ack("R9 nested ack");
        do_eoi("R9 retire highest");
        do_ack("R9 re-ack");
        do_eoi("R9");
        do_eoi("R9");
        do_ack("R7");
        do_eoi("R9");

        // R11 soft reset, then R10 priority zero
        soft_reset();
        for (int i = 0; i < N; i++) chk_src(i, "R11 defaults");
        bus_read(OFS_CTP, d);
        check(d == 32'd15, "R11 ctp", d, 15);
        set_ctp(0, "R10");
        cfg(9, 0, 1, 1, 0, 8'h99, "R10");
        do_ack("R10 prio zero spurious");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            int s = $urandom_range(0, N - 1);
            case (op)
                0, 1, 2: set_in(s, !m_in[s], "R6 random input");
                3, 4: cfg(s, ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                          1'($urandom_range(0, 1)), $urandom_range(0, 15),
                          $urandom_range(0, 255), "R4 random cfg");
                5: set_ctp($urandom_range(0, 3) == 0 ? $urandom_range(0, 15) : $urandom_range(0, 4),
                           "R5 random ctp");
                6, 7: do_ack("R7 random ack");
                8: do_eoi("R9 random eoi");
                default: begin
                    if ($urandom_range(0, 19) == 0) soft_reset();
                    else chk_src(s, "R2 random readback");
                end
            endcase
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule